// File: doc/BRIEF.md
# Colour-Filter Pattern Coefficient Selector

This block walks a repeating colour-filter pattern in step with the pixel stream and names, for every valid pixel, which of four shared gain/offset coefficient sets applies to it. The pattern has two lines that alternate from one image line to the next. Each line has its own length of one to four pixel positions, and each position carries a 2-bit set index. A pixel-valid strobe moves the position forward. A line-start strobe restarts the position and switches to the other pattern line. A frame-start strobe restarts on pattern line 0.

A simple write port loads the coefficient registers and the pattern description. The pattern description is staged: a write to it only reaches the pixel path at the next line-start or frame-start strobe, so a line never changes its pattern partway through. Coefficient writes apply at once. For each valid pixel the block gives the selected set index and that set's gain and signed offset. All of these are registered, and they appear one clock after the pixel.

Top module: `cfa_coef_sel`

## Requirements
- R1: After reset, out_valid is 0 and out_set, out_gain and out_offset are 0. Every coefficient register and pattern register is 0, so every pixel selects set 0 with gain 0 and offset 0 until something is written.
- R2: out_valid is high in the clock after a cycle with pix_valid high, and low otherwise. While out_valid is low, out_set, out_gain and out_offset keep their last values.
- R3: The line-0 pattern byte sits at address 8 and the line-1 pattern byte at address 9. Position k of a line takes its set index from bits [2k+1:2k] of that line's byte.
- R4: The definition register sits at address 10. Bits [1:0] give the count for line 0 and bits [3:2] the count for line 1. A count of N means a period of N+1 pixels, and after the last position the position goes back to 0.
- R5: A line-start strobe sets the position to 0 and switches the active pattern line between 0 and 1.
- R6: A frame-start strobe sets the active line to 0 and the position to 0. It wins over a line-start strobe in the same cycle.
- R7: Writes to addresses 8, 9 and 10 have no effect on selection until the next line-start or frame-start strobe. A write made in the same cycle as a strobe waits for the strobe after that.
- R8: Gain of set k is written at address k and offset of set k at address 4+k, for k = 0..3. The outputs show the selected set's values. A coefficient write is seen by pixels from the next cycle on. The offset is an 8-bit two's-complement value.
- R9: A pixel given in the same cycle as a strobe is the first pixel of the new line. It uses position 0 of the new line with the newly loaded pattern.
- R10: Cycles with pix_valid low do not move the pattern position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| pix_valid | input | 1 | A pixel is present this cycle |
| line_start | input | 1 | Start of an image line |
| frame_start | input | 1 | Start of a frame |
| out_valid | output | 1 | Registered pixel-valid for the outputs below |
| out_set | output | 2 | Selected coefficient set index |
| out_gain | output | 8 | Gain of the selected set |
| out_offset | output | 8 | Signed offset of the selected set |

## Verification
The bench builds the block with its default parameters: four coefficient sets, patterns of up to four positions and 8-bit coefficients. These values make every set index and every pattern length from one to four pixels reachable. Rewriting the definition register between lines moves the two lines through periods of 4 and 2, and then 1 and 3, so wrap at every position is exercised. A pixel landing on a strobe cycle, a strobe arriving together with a staged write, and a coefficient change between two pixels of the same set are also reached.

// File: rtl/cfa_sel_pkg.sv
package cfa_sel_pkg;

  localparam int LINES = 2;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_GAIN,
    RK_OFFS,
    RK_LCFG,
    RK_LDEF
  } reg_kind_e;

  // Address plan: gains, then offsets, then one pattern byte per line, then lengths.
  function automatic reg_kind_e reg_kind(input int unsigned addr, input int unsigned sets);
    if (addr < sets)                return RK_GAIN;
    else if (addr < 2 * sets)       return RK_OFFS;
    else if (addr < 2 * sets + 2)   return RK_LCFG;
    else if (addr == 2 * sets + 2)  return RK_LDEF;
    else                            return RK_NONE;
  endfunction

endpackage

// File: rtl/cfa_pattern_regs.sv
module cfa_pattern_regs
  import cfa_sel_pkg::*;
#(
  parameter int SET_CNT = 4,
  parameter int POS_CNT = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int SET_W  = $clog2(SET_CNT),
  localparam int POS_W  = $clog2(POS_CNT),
  localparam int CFG_W  = SET_W * POS_CNT
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              load,
  output logic [LINES-1:0][CFG_W-1:0]       eff_cfg,
  output logic [LINES-1:0][POS_W-1:0]       eff_cnt,
  output logic [LINES-1:0][POS_W-1:0]       act_cnt
);

  localparam int CFG_BASE = 2 * SET_CNT;
  localparam int DEF_ADDR = 2 * SET_CNT + LINES;

  logic [LINES-1:0][CFG_W-1:0] stg_cfg, act_cfg;
  logic [LINES-1:0][POS_W-1:0] stg_cnt, act_cnt_q;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_cfg[l]   <= '0;
        stg_cnt[l]   <= '0;
        act_cfg[l]   <= '0;
        act_cnt_q[l] <= '0;
      end else begin
        // the active copy takes the staged value as it stood before this edge
        if (load) begin
          act_cfg[l]   <= stg_cfg[l];
          act_cnt_q[l] <= stg_cnt[l];
        end
        if (wr_en && wr_addr == ADDR_W'(CFG_BASE + l))
          stg_cfg[l] <= wr_data[CFG_W-1:0];
        if (wr_en && wr_addr == ADDR_W'(DEF_ADDR))
          stg_cnt[l] <= wr_data[l*POS_W +: POS_W];
      end
    end
  end

  // on a strobe cycle the pixel path already sees the pattern it is about to load
  assign eff_cfg = load ? stg_cfg : act_cfg;
  assign eff_cnt = load ? stg_cnt : act_cnt_q;
  assign act_cnt = act_cnt_q;

  a_r7_active_stable: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_cfg) && $stable(act_cnt_q)));

endmodule

// File: rtl/cfa_pos_seq.sv
module cfa_pos_seq
  import cfa_sel_pkg::*;
#(
  parameter int SET_CNT = 4,
  parameter int POS_CNT = 4,
  localparam int SET_W  = $clog2(SET_CNT),
  localparam int POS_W  = $clog2(POS_CNT),
  localparam int CFG_W  = SET_W * POS_CNT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pix_valid,
  input  logic                          line_start,
  input  logic                          frame_start,
  input  logic [LINES-1:0][CFG_W-1:0]   eff_cfg,
  input  logic [LINES-1:0][POS_W-1:0]   eff_cnt,
  output logic [SET_W-1:0]              sel_idx,
  output logic                          cur_line,
  output logic [POS_W-1:0]              cur_pos
);

  logic             line_q;
  logic [POS_W-1:0] pos_q;
  logic             e_line;
  logic [POS_W-1:0] e_pos;
  logic [POS_W-1:0] n_pos;

  always_comb begin
    if (frame_start) begin
      e_line = 1'b0;
      e_pos  = '0;
    end else if (line_start) begin
      e_line = ~line_q;
      e_pos  = '0;
    end else begin
      e_line = line_q;
      e_pos  = pos_q;
    end
    sel_idx = eff_cfg[e_line][e_pos*SET_W +: SET_W];
    if (!pix_valid)                  n_pos = e_pos;
    else if (e_pos == eff_cnt[e_line]) n_pos = '0;
    else                             n_pos = e_pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      line_q <= e_line;
      pos_q  <= n_pos;
    end
  end

  assign cur_line = line_q;
  assign cur_pos  = pos_q;

  a_r5_line_toggle: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start) |=> (line_q != $past(line_q)));

  a_r5_pos_restart: assert property (@(posedge clk) disable iff (rst)
    ((line_start || frame_start) && !pix_valid) |=> (pos_q == '0));

  a_r6_frame_line0: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (line_q == 1'b0));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!pix_valid && !line_start && !frame_start) |=> $stable(pos_q));

endmodule

// File: rtl/cfa_coef_bank.sv
module cfa_coef_bank
  import cfa_sel_pkg::*;
#(
  parameter int SET_CNT = 4,
  parameter int COEF_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int SET_W  = $clog2(SET_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [SET_W-1:0]   rd_idx,
  output logic [COEF_W-1:0]  rd_gain,
  output logic [COEF_W-1:0]  rd_offs
);

  logic [COEF_W-1:0] gain_mem [SET_CNT];
  logic [COEF_W-1:0] offs_mem [SET_CNT];
  reg_kind_e         kind;
  logic [SET_W-1:0]  g_idx, o_idx;

  assign kind  = reg_kind(int'(wr_addr), SET_CNT);
  assign g_idx = wr_addr[SET_W-1:0];
  assign o_idx = SET_W'(wr_addr - ADDR_W'(SET_CNT));

  for (genvar k = 0; k < SET_CNT; k++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        gain_mem[k] <= '0;
        offs_mem[k] <= '0;
      end else if (wr_en) begin
        if (kind == RK_GAIN && g_idx == SET_W'(k)) gain_mem[k] <= wr_data[COEF_W-1:0];
        if (kind == RK_OFFS && o_idx == SET_W'(k)) offs_mem[k] <= wr_data[COEF_W-1:0];
      end
    end
  end

  // registered read: a write in the same cycle is seen by the next pixel
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_gain <= '0;
      rd_offs <= '0;
    end else if (rd_en) begin
      rd_gain <= gain_mem[rd_idx];
      rd_offs <= offs_mem[rd_idx];
    end
  end

  a_r8_idle_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_gain) && $stable(rd_offs)));

endmodule

// File: rtl/cfa_coef_sel.sv
module cfa_coef_sel
  import cfa_sel_pkg::*;
#(
  parameter int SET_CNT = 4,
  parameter int POS_CNT = 4,
  parameter int COEF_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int SET_W  = $clog2(SET_CNT),
  localparam int POS_W  = $clog2(POS_CNT),
  localparam int CFG_W  = SET_W * POS_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pix_valid,
  input  logic              line_start,
  input  logic              frame_start,
  output logic              out_valid,
  output logic [SET_W-1:0]  out_set,
  output logic [COEF_W-1:0] out_gain,
  output logic [COEF_W-1:0] out_offset
);

  logic                        strobe;
  logic [LINES-1:0][CFG_W-1:0] eff_cfg;
  logic [LINES-1:0][POS_W-1:0] eff_cnt;
  logic [LINES-1:0][POS_W-1:0] act_cnt;
  logic [SET_W-1:0]            sel_idx;
  logic                        cur_line;
  logic [POS_W-1:0]            cur_pos;

  assign strobe = line_start | frame_start;

  cfa_pattern_regs #(
    .SET_CNT(SET_CNT), .POS_CNT(POS_CNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_pat (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(strobe), .eff_cfg(eff_cfg), .eff_cnt(eff_cnt), .act_cnt(act_cnt)
  );

  cfa_pos_seq #(
    .SET_CNT(SET_CNT), .POS_CNT(POS_CNT)
  ) u_seq (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_start(line_start),
    .frame_start(frame_start), .eff_cfg(eff_cfg), .eff_cnt(eff_cnt),
    .sel_idx(sel_idx), .cur_line(cur_line), .cur_pos(cur_pos)
  );

  cfa_coef_bank #(
    .SET_CNT(SET_CNT), .COEF_W(COEF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(pix_valid), .rd_idx(sel_idx), .rd_gain(out_gain), .rd_offs(out_offset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_set   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_set <= sel_idx;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> (!out_valid && $stable(out_set)));

  a_r4_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    cur_pos <= act_cnt[cur_line]);

endmodule

// File: tb/cfa_coef_sel_test.sv
module cfa_coef_sel_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       pix_valid, line_start, frame_start;
  logic       out_valid;
  logic [1:0] out_set;
  logic [7:0] out_gain, out_offset;

  always #5 clk = ~clk;

  cfa_coef_sel uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start),
    .out_valid(out_valid), .out_set(out_set), .out_gain(out_gain), .out_offset(out_offset)
  );

  typedef struct {
    bit         v;
    logic [1:0] s;
    logic [7:0] g;
    logic [7:0] o;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 0;
  bit   done   = 0;
  string req = "R1";

  // reference model state
  logic [7:0] m_stg_cfg [2];
  logic [7:0] m_act_cfg [2];
  logic [1:0] m_stg_cnt [2];
  logic [1:0] m_act_cnt [2];
  logic [7:0] m_gain [4];
  logic [7:0] m_off  [4];
  logic       m_line;
  logic [1:0] m_pos;
  exp_t       m_last;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit pv, input bit ls, input bit fs,
                      input bit we, input logic [3:0] wa, input logic [7:0] wd);
    exp_t       e;
    logic       el;
    logic [1:0] ep;
    @(negedge clk);
    pix_valid = pv; line_start = ls; frame_start = fs;
    wr_en = we; wr_addr = wa; wr_data = wd;
    if (fs || ls) begin
      el = fs ? 1'b0 : ~m_line;
      ep = 2'd0;
      for (int l = 0; l < 2; l++) begin
        m_act_cfg[l] = m_stg_cfg[l];
        m_act_cnt[l] = m_stg_cnt[l];
      end
    end else begin
      el = m_line;
      ep = m_pos;
    end
    e = m_last;
    e.v = 1'b0;
    e.tag = req;
    if (pv) begin
      e.v = 1'b1;
      e.s = m_act_cfg[el][ep*2 +: 2];
      e.g = m_gain[e.s];
      e.o = m_off[e.s];
      ep  = (ep == m_act_cnt[el]) ? 2'd0 : ep + 2'd1;
    end
    m_last = e;
    m_line = el;
    m_pos  = ep;
    if (we) begin
      if (wa < 4)        m_gain[wa[1:0]] = wd;
      else if (wa < 8)   m_off[wa[1:0]]  = wd;
      else if (wa == 8)  m_stg_cfg[0]    = wd;
      else if (wa == 9)  m_stg_cfg[1]    = wd;
      else if (wa == 10) begin
        m_stg_cnt[0] = wd[1:0];
        m_stg_cnt[1] = wd[3:2];
      end
    end
    q.push_back(e);
  endtask

  task automatic pix(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 4'd0, 8'd0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(0, 0, 0, 1, a, d);
  endtask

  // monitor: the item driven at a falling edge is due just after the next rising edge
  always @(posedge clk) begin
    #2;
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(out_valid == e.v, e.tag, "out_valid", out_valid, e.v);
      check(out_set == e.s,   e.tag, "out_set",   out_set,   e.s);
      check(out_gain == e.g,  e.tag, "out_gain",  out_gain,  e.g);
      check(out_offset == e.o, e.tag, "out_offset", out_offset, e.o);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    pix_valid = 0; line_start = 0; frame_start = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    for (int l = 0; l < 2; l++) begin
      m_stg_cfg[l] = '0; m_act_cfg[l] = '0; m_stg_cnt[l] = '0; m_act_cnt[l] = '0;
    end
    for (int k = 0; k < 4; k++) begin
      m_gain[k] = '0; m_off[k] = '0;
    end
    m_line = 0; m_pos = 0;
    m_last.v = 0; m_last.s = '0; m_last.g = '0; m_last.o = '0; m_last.tag = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(out_set == 2'd0,   "R1", "reset out_set", out_set, 0);
    check(out_gain == 8'd0,  "R1", "reset out_gain", out_gain, 0);
    check(out_offset == 8'd0, "R1", "reset out_offset", out_offset, 0);
    rst = 1'b0;
    mon_on = 1;

    // R1: unprogrammed pattern selects set 0 everywhere
    req = "R1";
    pix(3);
    step(1, 1, 0, 0, 4'd0, 8'd0);
    pix(2);

    // R8: coefficient registers
    req = "R8";
    wr(4'd0, 8'h10); wr(4'd1, 8'h20); wr(4'd2, 8'h30); wr(4'd3, 8'h40);
    wr(4'd4, 8'hF0); wr(4'd5, 8'h05); wr(4'd6, 8'h80); wr(4'd7, 8'h7F);
    pix(2);

    // R7: staged pattern writes do not reach the current line
    req = "R7";
    wr(4'd8, 8'hE4);   // line 0: positions 0..3 -> sets 0,1,2,3
    wr(4'd9, 8'h1B);   // line 1: positions 0..3 -> sets 3,2,1,0
    wr(4'd10, 8'h07);  // line 0 count 3 (4 pixels), line 1 count 1 (2 pixels)
    pix(3);

    // R9 and R6: pixel on the frame-start cycle is position 0 of line 0
    req = "R9";
    step(1, 0, 1, 0, 4'd0, 8'd0);
    // R3 and R4: line 0 walks 1,2,3 then wraps to 0
    req = "R4";
    pix(7);
    // R10: gaps do not move the position
    req = "R10";
    step(0, 0, 0, 0, 4'd0, 8'd0);
    pix(1);
    step(0, 0, 0, 0, 4'd0, 8'd0);
    step(0, 0, 0, 0, 4'd0, 8'd0);
    pix(2);
    // R5: line start without a pixel, then line 1 with period 2
    req = "R5";
    step(0, 1, 0, 0, 4'd0, 8'd0);
    req = "R3";
    pix(5);
    // R9: pixel on a line-start cycle
    req = "R9";
    step(1, 1, 0, 0, 4'd0, 8'd0);
    pix(3);
    // R6: frame start and line start together go to line 0
    req = "R6";
    step(1, 1, 1, 0, 4'd0, 8'd0);
    pix(4);

    // R7: new lengths staged mid-line; current line keeps period 4
    req = "R7";
    wr(4'd10, 8'h08);  // line 0 count 0 (1 pixel), line 1 count 2 (3 pixels)
    pix(5);
    req = "R4";
    step(0, 1, 0, 0, 4'd0, 8'd0);   // line 1, period 3
    pix(7);
    step(1, 1, 0, 0, 4'd0, 8'd0);   // line 0, period 1
    pix(3);

    // R7: write in the same cycle as a strobe waits for the strobe after it
    req = "R7";
    step(0, 1, 0, 1, 4'd9, 8'hFF);  // line 1 keeps 0x1B
    pix(4);
    step(1, 1, 0, 0, 4'd0, 8'd0);   // line 0 now loads, line 1 byte staged
    pix(1);
    step(1, 1, 0, 0, 4'd0, 8'd0);   // line 1 uses 0xFF
    pix(3);

    // R8: coefficient change seen by the very next pixel
    req = "R8";
    step(1, 0, 1, 0, 4'd0, 8'd0);
    step(1, 0, 0, 1, 4'd0, 8'hA5);
    pix(2);
    wr(4'd7, 8'h81);
    step(0, 1, 0, 0, 4'd0, 8'd0);
    pix(2);

    // R2: idle tail, outputs hold
    req = "R2";
    repeat (3) step(0, 0, 0, 0, 4'd0, 8'd0);
    step(0, 0, 0, 0, 4'd0, 8'd0);
    repeat (3) @(posedge clk);
    #3;
    check(q.size() == 0, "R2", "pending items", q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule